// File: doc/BRIEF.md
# Multicycle Processor Sequencer

This block is the control state machine for a small multicycle processor with an 8-bit datapath and 32-bit instructions. It steps the datapath through fetching the four instruction bytes one per cycle, a decode cycle, and then a short per-class tail for loads, stores, register-register arithmetic, add-immediate, conditional branch and jump. Every datapath control line comes straight from the state register, so all outputs are glitch-free Moore outputs.

The block is placed beside the datapath. The datapath feeds it the 6-bit opcode field from the instruction register, and the block drives the memory strobes, the instruction-register byte enables, the program-counter write controls, the ALU operand and operation selects, and the register-file write controls. The opcode is read only in the decode and memory-address cycles, so it must be valid from the end of the last fetch cycle until the memory-address cycle has finished.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the first cycle after it falls, the block is in fetch cycle 0 and shows that cycle's outputs.
- R2: The four fetch cycles run back to back. Each one drives `mem_rd`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00, `pc_we`=1 and `pc_src`=00. Fetch cycle k sets only bit k of `ir_we` (bit 0 first, bit 3 last).
- R3: After fetch cycle 3 comes decode, with `alu_a_sel`=0, `alu_b_sel`=11, `alu_op`=00 and all other outputs at 0.
- R4: A load (opcode 100000) or store (opcode 101000) goes from decode to an address cycle with `alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00.
- R5: For a load, the address cycle is followed by an access cycle with `mem_rd`=1 and `addr_sel`=1, then a write-back cycle with `dst_sel`=0, `reg_we`=1 and `wb_sel`=1.
- R6: For a store, the address cycle is followed by one cycle with `mem_wr`=1 and `addr_sel`=1.
- R7: A register-register op (opcode 000000) runs an execute cycle with `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10, then a write-back with `dst_sel`=1, `reg_we`=1 and `wb_sel`=0.
- R8: A branch (opcode 000100) runs one cycle with `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_we_cond`=1 and `pc_src`=01.
- R9: A jump (opcode 000010) runs one cycle with `pc_we`=1 and `pc_src`=10.
- R10: An add-immediate (opcode 001000) runs an execute cycle with `alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00, then a write-back with `dst_sel`=0, `reg_we`=1 and `wb_sel`=0.
- R11: Any other opcode at decode sends the block back to fetch cycle 0 without touching memory, registers or the program counter.
- R12: The last cycle of every instruction class is followed by fetch cycle 0. In every cycle, any output not named for that cycle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| ir_we | output | 4 | Instruction register byte write enables |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write when the ALU reports zero |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant one, 10 immediate, 11 branch offset |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| reg_we | output | 1 | Register file write enable |
| wb_sel | output | 1 | Write-back source: 0 ALU result register, 1 memory data register |

## Verification
Because every output is a pure function of the state, a wrong state shows at the ports in the very cycle the state is entered: the control word in that cycle stops matching the expected one for the instruction. The bench compares the full control word every cycle of every instruction class, so a misrouted dispatch, a swapped fetch lane or a missing return to fetch shows up at most one cycle after the faulty transition. Reset in the middle of an instruction and an unknown opcode are covered to show that the block recovers to fetch cycle 0.

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel,
  output logic [3:0] ir_we,
  output logic       pc_we,
  output logic       pc_we_cond,
  output logic [1:0] pc_src,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic       dst_sel,
  output logic       reg_we,
  output logic       wb_sel
);

  localparam logic [5:0] OP_RR   = 6'b000000;
  localparam logic [5:0] OP_LD   = 6'b100000;
  localparam logic [5:0] OP_ST   = 6'b101000;
  localparam logic [5:0] OP_BR   = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;
  localparam logic [5:0] OP_ADDI = 6'b001000;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_DEC, S_ADR, S_LDM, S_LDWB,
    S_STM, S_RX, S_RWB, S_BR, S_JMP, S_IX, S_IWB
  } state_t;

  state_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= S_F0;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx = S_F0;
    case (st)
      S_F0:  st_nx = S_F1;
      S_F1:  st_nx = S_F2;
      S_F2:  st_nx = S_F3;
      S_F3:  st_nx = S_DEC;
      S_DEC: begin
        case (opcode)
          OP_LD, OP_ST: st_nx = S_ADR;
          OP_RR:        st_nx = S_RX;
          OP_BR:        st_nx = S_BR;
          OP_JMP:       st_nx = S_JMP;
          OP_ADDI:      st_nx = S_IX;
          default:      st_nx = S_F0;
        endcase
      end
      S_ADR: begin
        if (opcode == OP_LD)      st_nx = S_LDM;
        else if (opcode == OP_ST) st_nx = S_STM;
        else                      st_nx = S_F0;
      end
      S_LDM: st_nx = S_LDWB;
      S_RX:  st_nx = S_RWB;
      S_IX:  st_nx = S_IWB;
      default: st_nx = S_F0;
    endcase
  end

  logic fetch;
  assign fetch = (st == S_F0) || (st == S_F1) || (st == S_F2) || (st == S_F3);

  always_comb begin
    mem_rd = 1'b0; mem_wr = 1'b0; addr_sel = 1'b0; ir_we = 4'b0000;
    pc_we = 1'b0; pc_we_cond = 1'b0; pc_src = 2'b00;
    alu_a_sel = 1'b0; alu_b_sel = 2'b00; alu_op = 2'b00;
    dst_sel = 1'b0; reg_we = 1'b0; wb_sel = 1'b0;
    if (fetch) begin
      mem_rd = 1'b1;
      ir_we = 4'b0001 << st[1:0];
      alu_b_sel = 2'b01;
      pc_we = 1'b1;
    end
    case (st)
      S_DEC: alu_b_sel = 2'b11;
      S_ADR, S_IX: begin alu_a_sel = 1'b1; alu_b_sel = 2'b10; end
      S_LDM: begin mem_rd = 1'b1; addr_sel = 1'b1; end
      S_LDWB: begin reg_we = 1'b1; wb_sel = 1'b1; end
      S_STM: begin mem_wr = 1'b1; addr_sel = 1'b1; end
      S_RX:  begin alu_a_sel = 1'b1; alu_op = 2'b10; end
      S_RWB: begin dst_sel = 1'b1; reg_we = 1'b1; end
      S_IWB: reg_we = 1'b1;
      S_BR:  begin alu_a_sel = 1'b1; alu_op = 2'b01; pc_we_cond = 1'b1; pc_src = 2'b01; end
      S_JMP: begin pc_we = 1'b1; pc_src = 2'b10; end
      default: ;
    endcase
  end

  assert_lane_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ir_we));
  assert_lane01_R2: assert property (@(posedge clk) disable iff (rst)
    ir_we[0] |=> ir_we[1]);
  assert_lane12_R2: assert property (@(posedge clk) disable iff (rst)
    ir_we[1] |=> ir_we[2]);
  assert_lane23_R2: assert property (@(posedge clk) disable iff (rst)
    ir_we[2] |=> ir_we[3]);
  assert_decode_follows_R3: assert property (@(posedge clk) disable iff (rst)
    ir_we[3] |=> (alu_b_sel == 2'b11 && !pc_we && !mem_rd));
  assert_no_rd_wr_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_store_ret_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_we[0]);
  assert_wb_ret_R12: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> ir_we[0]);
  assert_branch_ret_R8: assert property (@(posedge clk) disable iff (rst)
    pc_we_cond |=> ir_we[0]);
  assert_load_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (reg_we && wb_sel && !dst_sel));

endmodule

// File: tb/mcyc_ctrl_tb.sv
module mcyc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'b111111;
  logic mem_rd, mem_wr, addr_sel, pc_we, pc_we_cond, alu_a_sel, dst_sel, reg_we, wb_sel;
  logic [3:0] ir_we;
  logic [1:0] pc_src, alu_b_sel, alu_op;

  always #4 clk = ~clk;

  mcyc_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_src(pc_src),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .dst_sel(dst_sel), .reg_we(reg_we), .wb_sel(wb_sel)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [18:0] exp_q[$];
  string tag_q[$];

  function automatic logic [18:0] cw(input logic mr, mw, ad, input logic [3:0] irw,
      input logic pw, pwc, input logic [1:0] ps, input logic asel,
      input logic [1:0] bsel, aop, input logic dst, rw, wb);
    return {mr, mw, ad, irw, pw, pwc, ps, asel, bsel, aop, dst, rw, wb};
  endfunction

  function automatic logic [18:0] act();
    return {mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond, pc_src,
            alu_a_sel, alu_b_sel, alu_op, dst_sel, reg_we, wb_sel};
  endfunction

  function automatic logic [18:0] w_fetch(input int k);
    return cw(1, 0, 0, 4'(1 << k), 1, 0, 2'b00, 0, 2'b01, 2'b00, 0, 0, 0);
  endfunction

  logic [18:0] W_DEC, W_ADR, W_LDM, W_LDWB, W_STM, W_RX, W_RWB, W_BR, W_JMP, W_IX, W_IWB;
  initial begin
    W_DEC  = cw(0,0,0,4'b0,0,0,2'b00,0,2'b11,2'b00,0,0,0);
    W_ADR  = cw(0,0,0,4'b0,0,0,2'b00,1,2'b10,2'b00,0,0,0);
    W_LDM  = cw(1,0,1,4'b0,0,0,2'b00,0,2'b00,2'b00,0,0,0);
    W_LDWB = cw(0,0,0,4'b0,0,0,2'b00,0,2'b00,2'b00,0,1,1);
    W_STM  = cw(0,1,1,4'b0,0,0,2'b00,0,2'b00,2'b00,0,0,0);
    W_RX   = cw(0,0,0,4'b0,0,0,2'b00,1,2'b00,2'b10,0,0,0);
    W_RWB  = cw(0,0,0,4'b0,0,0,2'b00,0,2'b00,2'b00,1,1,0);
    W_BR   = cw(0,0,0,4'b0,0,1,2'b01,1,2'b00,2'b01,0,0,0);
    W_JMP  = cw(0,0,0,4'b0,1,0,2'b10,0,2'b00,2'b00,0,0,0);
    W_IX   = cw(0,0,0,4'b0,0,0,2'b00,1,2'b10,2'b00,0,0,0);
    W_IWB  = cw(0,0,0,4'b0,0,0,2'b00,0,2'b00,2'b00,0,1,0);
  end

  task automatic check(input logic [18:0] got, exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic push(input logic [18:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic push_fetch_dec(input string cls);
    for (int k = 0; k < 4; k++) push(w_fetch(k), {"R2 fetch ", cls});
    push(W_DEC, {"R3 decode ", cls});
  endtask

  // driver: called at a negedge where the design sits in fetch cycle 0
  task automatic run_instr(input logic [5:0] op, input string cls);
    int len;
    opcode = op;
    push_fetch_dec(cls);
    len = 5;
    case (op)
      6'b100000: begin push(W_ADR, "R4 addr LB"); push(W_LDM, "R5 load access");
                       push(W_LDWB, "R5 load wb"); len = 8; end
      6'b101000: begin push(W_ADR, "R4 addr SB"); push(W_STM, "R6 store"); len = 7; end
      6'b000000: begin push(W_RX, "R7 rr exec"); push(W_RWB, "R7 rr wb"); len = 7; end
      6'b000100: begin push(W_BR, "R8 branch"); len = 6; end
      6'b000010: begin push(W_JMP, "R9 jump"); len = 6; end
      6'b001000: begin push(W_IX, "R10 addi exec"); push(W_IWB, "R10 addi wb"); len = 7; end
      default: ;
    endcase
    repeat (len) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) check(act(), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  logic done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 check(act(), w_fetch(0), "R1 reset state");
    @(negedge clk);
    rst = 1'b0;
    run_instr(6'b100000, "LB");
    run_instr(6'b101000, "SB");
    run_instr(6'b000000, "RR");
    run_instr(6'b000100, "BEQ");
    run_instr(6'b000010, "J");
    run_instr(6'b001000, "ADDI");
    run_instr(6'b111111, "R11 unknown");
    run_instr(6'b100011, "R11 unknown");
    // R12 back-to-back classes return to fetch 0
    run_instr(6'b000010, "J");
    run_instr(6'b100000, "LB");
    // R1 reset in the middle of an instruction (during decode)
    opcode = 6'b000000;
    push_fetch_dec("pre-reset");
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #2 check(act(), w_fetch(0), "R1 reset mid-instruction");
    @(negedge clk);
    rst = 1'b0;
    run_instr(6'b001000, "ADDI after reset");
    run_instr(6'b101000, "SB after reset");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R12: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule